// File: doc/BRIEF.md
# Sampled Early-Warning Interrupt Filter

This block turns a raw comparator flag into an early power-failure interrupt for a processor. The flag is high while a monitored supply sits below its warning trip point. The block passes the flag through a two-stage synchronizer. A divider off the system clock makes a slow sample tick, nominally about 33 µs apart. The block looks at the flag only on those ticks, so short dips and noise between ticks never reach the interrupt.

The active-low interrupt asserts only after a run of consecutive below-threshold samples, three by default. Any in-tolerance sample clears the run. While the main-supply-good flag is low, below-threshold samples are held back and the run stays at zero. This keeps the interrupt from firing on power-up before the main supply is valid. An asserted interrupt stays on until the first sample that finds the monitored input back in tolerance. The supply-good flag is a synchronous signal from the same clock domain, and it is read on the sample tick.

Top module: `ewarn_irq_filter`

## Requirements
- R1: While rst_n is low, and after its release until a qualifying run of samples, warn_irq_n_o is 1 (inactive) and the run count is zero.
- R2: A sample is taken every CLK_DIV clocks, at rising edges CLK_DIV, 2·CLK_DIV, ... counted from the first rising edge after rst_n goes high. warn_irq_n_o changes only just after such a sampling edge.
- R3: below_trip_i passes through exactly two flops. A value captured at rising edge e is the value that a sample at edge e+2 uses.
- R4: When CONFIRM_SAMPLES (default 3) consecutive samples see below_trip_i = 1 with supply_good_i = 1, warn_irq_n_o goes to 0 right after the sampling edge of the last of them, and not before.
- R5: A sample that sees below_trip_i = 0 resets the run count to zero, so a new full run is needed.
- R6: A sample taken while supply_good_i = 0 never asserts the interrupt and leaves the run count at zero. Counting restarts from one at the first sample after supply_good_i returns to 1.
- R7: An asserted interrupt is released (warn_irq_n_o = 1) at the first sample that sees below_trip_i = 0, whatever supply_good_i is. It stays asserted through further below-threshold samples, even with supply_good_i = 0.
- R8: Flag levels that are present only between two samples have no effect on the run count or on the output.
- R9: The run count saturates at CONFIRM_SAMPLES while the input stays below threshold, and the interrupt holds at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| below_trip_i | input | 1 | Asynchronous comparator flag, 1 = monitored input below its trip point |
| supply_good_i | input | 1 | Synchronous flag, 1 = main supply above its own trip point |
| warn_irq_n_o | output | 1 | Early-warning interrupt, active low |

## Verification
A wrong run count shows at the port as an interrupt that falls one sample period early or late. That is a shift of CLK_DIV clocks from the edge where the third qualifying sample lands. A lost or extra synchronizer stage moves the effect of a flag change across a sample boundary. So a change made two or three clocks before a sampling edge shows up one whole period off. A state that fails to leave the alert condition, or a supply gate that leaks, shows within one sample period as a missed release or an early assertion.

// File: rtl/ewf_pkg.sv
package ewf_pkg;

    typedef enum logic [1:0] {
        FLT_CLEAR  = 2'd0,
        FLT_ARMING = 2'd1,
        FLT_ALERT  = 2'd2
    } flt_state_e;

endpackage

// File: rtl/ewf_tick_gen.sv
module ewf_tick_gen #(
    parameter int DIV = 3300
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } tick_regs_t;

    tick_regs_t cur_q, nxt_d;

    assign tick_o = (cur_q.cnt == LAST);

    always_comb begin
        nxt_d = cur_q;
        if (tick_o) nxt_d.cnt = '0;
        else        nxt_d.cnt = cur_q.cnt + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.cnt <= LAST);

    generate
        if (DIV > 1) begin : g_pulse
            assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/ewf_sync.sv
module ewf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_regs_t;

    sync_regs_t cur_q, nxt_d;

    generate
        if (STAGES > 1) begin : g_multi
            always_comb begin
                nxt_d = cur_q;
                nxt_d.chain = {cur_q.chain[STAGES-2:0], async_i};
            end
        end else begin : g_single
            always_comb begin
                nxt_d = cur_q;
                nxt_d.chain = async_i;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign sync_o = cur_q.chain[STAGES-1];

    assert_sync_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cur_q.chain[0]) |=> cur_q.chain[(STAGES > 1) ? 1 : 0]);

endmodule

// File: rtl/ewf_confirm.sv
module ewf_confirm
    import ewf_pkg::*;
#(
    parameter int CONFIRM = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic below_i,
    input  logic supply_ok_i,
    output logic irq_n_o
);
    localparam int CW = $clog2(CONFIRM + 1);
    localparam logic [CW-1:0] FULL = CW'(CONFIRM);
    localparam logic [CW-1:0] PRE  = CW'(CONFIRM - 1);

    typedef struct packed {
        flt_state_e     st;
        logic [CW-1:0]  cnt;
        logic           irq_n;
    } flt_regs_t;

    localparam flt_regs_t IDLE = '{st: FLT_CLEAR, cnt: '0, irq_n: 1'b1};

    flt_regs_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (tick_i) begin
            if (!below_i) begin
                nxt_d = IDLE;
            end else if (cur_q.st == FLT_ALERT) begin
                nxt_d.cnt = FULL;
            end else if (!supply_ok_i) begin
                nxt_d = IDLE;
            end else if (cur_q.cnt == PRE) begin
                nxt_d.st    = FLT_ALERT;
                nxt_d.cnt   = FULL;
                nxt_d.irq_n = 1'b0;
            end else begin
                nxt_d.st  = FLT_ARMING;
                nxt_d.cnt = cur_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= IDLE;
        else        cur_q <= nxt_d;
    end

    assign irq_n_o = cur_q.irq_n;

    assert_fall_after_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cur_q.irq_n) |-> $past(tick_i && below_i && supply_ok_i && cur_q.cnt == PRE));

    assert_clean_sample_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !below_i) |=> (cur_q.cnt == '0 && cur_q.irq_n));

    assert_supply_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !supply_ok_i && cur_q.irq_n) |=> (cur_q.irq_n && cur_q.cnt == '0));

    assert_release_on_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cur_q.irq_n) |-> $past(tick_i && !below_i));

    assert_quiet_between_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> ($stable(cur_q.irq_n) && $stable(cur_q.cnt)));

    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.cnt <= FULL);

endmodule

// File: rtl/ewarn_irq_filter.sv
module ewarn_irq_filter #(
    parameter int CLK_DIV         = 3300,
    parameter int SYNC_STAGES     = 2,
    parameter int CONFIRM_SAMPLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic below_trip_i,
    input  logic supply_good_i,
    output logic warn_irq_n_o
);
    logic sample_tick;
    logic below_sync;

    ewf_tick_gen #(.DIV(CLK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (sample_tick)
    );

    ewf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (below_trip_i),
        .sync_o  (below_sync)
    );

    ewf_confirm #(.CONFIRM(CONFIRM_SAMPLES)) u_confirm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (sample_tick),
        .below_i     (below_sync),
        .supply_ok_i (supply_good_i),
        .irq_n_o     (warn_irq_n_o)
    );

    assert_change_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(warn_irq_n_o) |-> $past(sample_tick));

endmodule

// File: tb/sim_ewarn_irq_filter.sv
module sim_ewarn_irq_filter;
    localparam int DIV = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic below = 1'b0;
    logic sup = 1'b1;
    logic irq_n;
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    ewarn_irq_filter #(.CLK_DIV(DIV), .SYNC_STAGES(2), .CONFIRM_SAMPLES(3)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .below_trip_i  (below),
        .supply_good_i (sup),
        .warn_irq_n_o  (irq_n)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at cyc %0d: irq_n=%b expected %b", req, cyc, act, exp);
        end
    endtask

    task automatic to_tick();
        do @(negedge clk); while (cyc % DIV != 0);
    endtask

    task automatic to_phase(input int p);
        do @(negedge clk); while (cyc % DIV != p);
    endtask

    task automatic settle_clear();
        below = 1'b0;
        sup = 1'b1;
        to_tick();
        to_tick();
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 during reset", irq_n, 1'b1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 after release", irq_n, 1'b1);
        to_tick();
        chk("R1 first sample clean", irq_n, 1'b1);
    endtask

    task automatic t_confirm();
        settle_clear();
        below = 1'b1;
        to_tick();
        chk("R4 one sample", irq_n, 1'b1);
        to_tick();
        chk("R4 two samples", irq_n, 1'b1);
        repeat (DIV - 1) @(negedge clk);
        chk("R2 no change before third edge", irq_n, 1'b1);
        to_tick();
        chk("R4 three samples", irq_n, 1'b0);
        to_tick();
        to_tick();
        chk("R9 held while below", irq_n, 1'b0);
    endtask

    task automatic t_release();
        below = 1'b0;
        repeat (DIV - 1) @(negedge clk);
        chk("R8 no release between samples", irq_n, 1'b0);
        to_tick();
        chk("R7 release on clean sample", irq_n, 1'b1);
    endtask

    task automatic t_run_reset();
        settle_clear();
        below = 1'b1;
        to_tick();
        to_tick();
        below = 1'b0;
        to_tick();
        below = 1'b1;
        to_tick();
        to_tick();
        chk("R5 run restarted", irq_n, 1'b1);
        to_tick();
        chk("R5 full new run", irq_n, 1'b0);
        t_release();
    endtask

    task automatic t_gate();
        settle_clear();
        sup = 1'b0;
        below = 1'b1;
        for (int i = 0; i < 5; i++) begin
            to_tick();
            chk("R6 blocked while supply low", irq_n, 1'b1);
        end
        sup = 1'b1;
        to_tick();
        to_tick();
        chk("R6 count restarted after supply good", irq_n, 1'b1);
        to_tick();
        chk("R6 asserts after fresh run", irq_n, 1'b0);
        sup = 1'b0;
        to_tick();
        to_tick();
        chk("R7 held with supply low", irq_n, 1'b0);
        below = 1'b0;
        to_tick();
        chk("R7 release with supply low", irq_n, 1'b1);
        sup = 1'b1;
    endtask

    task automatic t_glitch();
        settle_clear();
        below = 1'b1;
        for (int i = 0; i < 3; i++) begin
            repeat (2) @(negedge clk);
            below = 1'b0;
            repeat (2) @(negedge clk);
            below = 1'b1;
            to_tick();
            chk(i < 2 ? "R8 mid-period dip ignored" : "R8 run completes across dips",
                irq_n, (i < 2) ? 1'b1 : 1'b0);
        end
        t_release();
    endtask

    task automatic t_sync_latency();
        settle_clear();
        below = 1'b1;
        repeat (3) to_tick();
        chk("R4 active before latency test", irq_n, 1'b0);
        to_phase(DIV - 2);
        below = 1'b0;
        to_tick();
        chk("R3 late change not yet seen", irq_n, 1'b0);
        to_tick();
        chk("R3 late change seen next sample", irq_n, 1'b1);
        to_phase(DIV - 3);
        below = 1'b1;
        to_tick();
        to_tick();
        chk("R3 early change counted, two samples", irq_n, 1'b1);
        to_tick();
        chk("R3 early change counted, three samples", irq_n, 1'b0);
        t_release();
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        t_reset();
        t_confirm();
        t_release();
        t_run_reset();
        t_gate();
        t_glitch();
        t_sync_latency();
        done = 1;
        report();
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired: done=%0d expected 1", done);
            report();
        end
    end

endmodule